// File: doc/BRIEF.md
# Trace Ring Recorder

The recorder captures one 256-bit record on every clock cycle into a circular RAM, so that the most recent cycles of a datapath's activity can be examined afterwards. Recording halts while any reader freezes it. The stored entries then stay fixed and can be drained at leisure.

Two identical reader ports are provided, so that two independent agents can inspect the buffer without disturbing each other. Each port has a pointer register and a data register. Reading the pointer register shows the shared write position together with the port's own read position and freeze flag. Each data read returns one 64-bit quarter of an entry, one cycle after the request, and then moves that port's read position forward. The depth is a power-of-two parameter of at least 2. A depth of zero removes all storage and logic, and every output is then tied to zero.

Top module: `trace_ring`

## Requirements
- R1: While reset is high, and right after it is released, each port's pointer readout is `DEPTH` in bits 63:32 and zero in bits 31:0, and `dat_valid` is low.
- R2: On each cycle in which recording is not frozen, `rec_in` is stored at the write position, which then advances by one and wraps to 0 after entry DEPTH-1.
- R3: The pointer readout of port p has the write position ORed with `DEPTH` in bits 63:32, the freeze flag in bit 31, and the read position in the low bits; all other bits are zero.
- R4: A pointer write on port p loads the read position from the low log2(DEPTH*4) bits of `ptr_wdata` and the freeze flag from bit 31; bits 63:32 and the bits in between are ignored.
- R5: While either port's freeze flag is set, no record is stored and the write position does not change.
- R6: A data request on port p (`dat_re` high with `ptr_we` low) raises `dat_valid` on the next cycle with `dat_rdata` equal to the quarter `rptr[1:0]` of entry `rptr >> 2`, where quarter 0 is record bits 63:0. The data is the entry content from before any store made on the same edge.
- R7: After each data request the read position advances by one and wraps modulo DEPTH*4.
- R8: The two ports keep separate read positions and freeze flags, and both may read in the same cycle.
- R9: When `ptr_we` and `dat_re` are both high on a port, the pointer write wins: no data is returned and no extra advance takes place.
- R10: With `DEPTH` = 0 every output is constantly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_in | input | 256 | Record to capture this cycle |
| ptr_we | input | 2 | Per-port pointer register write strobe |
| ptr_wdata | input | 2x64 | Per-port pointer register write value |
| ptr_rdata | output | 2x64 | Per-port pointer register readout |
| dat_re | input | 2 | Per-port data register read request |
| dat_rdata | output | 2x64 | Per-port returned doubleword |
| dat_valid | output | 2 | Per-port returned doubleword is valid |

## Verification
A write position that slips or wraps at the wrong point shows on the pointer readout in the very next cycle. It also shows later as data from the wrong entry. A lost freeze flag makes the upper readout half keep moving while frozen. A read position that mis-steps or selects the wrong quarter returns a mismatching doubleword one cycle after the request. The bench keeps its own shadow of the whole buffer and compares both readouts of both ports on every cycle. Each error is therefore seen within one cycle of when it arises.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int REC_W  = 256;
    localparam int DW     = 64;
    localparam int NPORT  = 2;
    localparam int QBITS  = 2;

    // Per-port visible state: freeze flag in bit 31, read position below.
    typedef struct packed {
        logic        frz;
        logic [30:0] rd;
    } port_state_t;

    function automatic logic [30:0] rd_step(input logic [30:0] cur,
                                            input logic [30:0] mask);
        return (cur + 31'd1) & mask;
    endfunction

    function automatic logic [63:0] pack_readout(input logic [31:0] wpos,
                                                 input logic [31:0] depth,
                                                 input port_state_t st);
        return {wpos | depth, st};
    endfunction
endpackage

// File: rtl/trace_store.sv
module trace_store
    import trace_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RPW  = AW + QBITS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [REC_W-1:0]            rec_in,
    input  logic                        frozen,
    input  logic [NPORT-1:0]            rd_en,
    input  logic [NPORT-1:0][RPW-1:0]   rd_pos,
    output logic [31:0]                 wpos,
    output logic [NPORT-1:0][DW-1:0]    rd_data
);
    logic [REC_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
        end else if (!frozen) begin
            wp_q <= wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !frozen) begin
            mem[wp_q] <= rec_in;
        end
    end

    assign wpos = 32'(wp_q);

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic [AW-1:0]    idx;
        logic [QBITS-1:0] qsel;
        assign idx  = rd_pos[p][RPW-1:QBITS];
        assign qsel = rd_pos[p][QBITS-1:0];

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[p] <= '0;
            end else if (rd_en[p]) begin
                rd_data[p] <= mem[idx][qsel*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/trace_port.sv
module trace_port
    import trace_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RPW  = AW + QBITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [31:0]     wdata,
    input  logic            re,
    input  logic [31:0]     wpos,
    output logic [63:0]     readout,
    output logic            frz,
    output logic            rd_go,
    output logic [RPW-1:0]  rd_pos,
    output logic            valid
);
    localparam logic [30:0] RMASK = 31'((64'(DEPTH) * 4) - 1);

    port_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.frz = wdata[31];
            st_d.rd  = wdata[30:0] & RMASK;
        end else if (re) begin
            st_d.rd  = rd_step(st_q.rd, RMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            valid <= 1'b0;
        end else begin
            st_q  <= st_d;
            valid <= rd_go;
        end
    end

    assign rd_go   = re && !we;
    assign rd_pos  = st_q.rd[RPW-1:0];
    assign frz     = st_q.frz;
    assign readout = pack_readout(wpos, 32'(DEPTH), st_q);

    logic unused_rd_hi;
    assign unused_rd_hi = ^st_q.rd[30:RPW];
endmodule

// File: rtl/trace_ring.sv
module trace_ring
    import trace_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [255:0]              rec_in,
    input  logic [1:0]                ptr_we,
    input  logic [1:0][63:0]          ptr_wdata,
    output logic [1:0][63:0]          ptr_rdata,
    input  logic [1:0]                dat_re,
    output logic [1:0][63:0]          dat_rdata,
    output logic [1:0]                dat_valid
);
    if (DEPTH > 0) begin : g_on
        localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
        localparam int RPW = AW + QBITS;

        logic [NPORT-1:0]          frz;
        logic [NPORT-1:0]          rd_go;
        logic [NPORT-1:0][RPW-1:0] rd_pos;
        logic [31:0]               wpos;
        logic                      unused_wr_hi;

        assign unused_wr_hi = ^{ptr_wdata[0][63:32], ptr_wdata[1][63:32]};

        trace_store #(.DEPTH(DEPTH)) u_store (
            .clk     (clk),
            .rst     (rst),
            .rec_in  (rec_in),
            .frozen  (|frz),
            .rd_en   (rd_go),
            .rd_pos  (rd_pos),
            .wpos    (wpos),
            .rd_data (dat_rdata)
        );

        for (genvar p = 0; p < NPORT; p++) begin : g_port
            trace_port #(.DEPTH(DEPTH)) u_port (
                .clk     (clk),
                .rst     (rst),
                .we      (ptr_we[p]),
                .wdata   (ptr_wdata[p][31:0]),
                .re      (dat_re[p]),
                .wpos    (wpos),
                .readout (ptr_rdata[p]),
                .frz     (frz[p]),
                .rd_go   (rd_go[p]),
                .rd_pos  (rd_pos[p]),
                .valid   (dat_valid[p])
            );
        end
    end else begin : g_off
        assign ptr_rdata = '0;
        assign dat_rdata = '0;
        assign dat_valid = '0;
    end
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
    parameter int DEPTH = 2048
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ptr_we,
    input logic [1:0][63:0]  ptr_wdata,
    input logic [1:0][63:0]  ptr_rdata,
    input logic [1:0]        dat_re,
    input logic [1:0]        dat_valid
);
    if (DEPTH > 0) begin : g_chk
        localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
        localparam int RPW = AW + 2;

        logic frozen;
        assign frozen = ptr_rdata[0][31] | ptr_rdata[1][31];

        // R5: write position holds while frozen
        assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
            frozen |=> $stable(ptr_rdata[0][63:32]));

        // R2: write position steps by one otherwise
        assert_wpos_step_R2: assert property (@(posedge clk) disable iff (rst)
            !frozen |=> ptr_rdata[0][32 +: AW] == AW'($past(ptr_rdata[0][32 +: AW]) + 1'b1));

        for (genvar p = 0; p < 2; p++) begin : g_p
            assert_reset_state_R1: assert property (@(posedge clk)
                rst |=> (ptr_rdata[p][31:0] == 32'd0) && !dat_valid[p]);

            assert_read_valid_R6: assert property (@(posedge clk) disable iff (rst)
                (dat_re[p] && !ptr_we[p]) |=> dat_valid[p]);

            assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
                (dat_re[p] && !ptr_we[p]) |=>
                    ptr_rdata[p][RPW-1:0] == RPW'($past(ptr_rdata[p][RPW-1:0]) + 1'b1));

            assert_ptr_load_R4: assert property (@(posedge clk) disable iff (rst)
                ptr_we[p] |=> (ptr_rdata[p][31] == $past(ptr_wdata[p][31])) &&
                              (ptr_rdata[p][RPW-1:0] == $past(ptr_wdata[p][RPW-1:0])));

            assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
                ptr_we[p] |=> !dat_valid[p]);
        end
    end
endmodule

bind trace_ring trace_ring_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/trace_ring_test.sv
module trace_ring_test;
    localparam int  DEPTH  = 2048;
    localparam int  RD     = DEPTH * 4;
    localparam time PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [255:0]      rec_in = '0;
    logic [1:0]        ptr_we = '0;
    logic [1:0][63:0]  ptr_wdata = '0;
    logic [1:0][63:0]  ptr_rdata;
    logic [1:0]        dat_re = '0;
    logic [1:0][63:0]  dat_rdata;
    logic [1:0]        dat_valid;
    logic [1:0][63:0]  z_rdata, z_data;
    logic [1:0]        z_valid;

    trace_ring #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rec_in(rec_in), .ptr_we(ptr_we),
        .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata), .dat_re(dat_re),
        .dat_rdata(dat_rdata), .dat_valid(dat_valid));

    trace_ring #(.DEPTH(0)) uut_zero (
        .clk(clk), .rst(rst), .rec_in(rec_in), .ptr_we(ptr_we),
        .ptr_wdata(ptr_wdata), .ptr_rdata(z_rdata), .dat_re(dat_re),
        .dat_rdata(z_data), .dat_valid(z_valid));

    always #(PERIOD/2) clk = ~clk;

    // shadow model
    logic [255:0] mmem [DEPTH];
    int           mw;
    int           mrp [2];
    logic         mfrz [2];
    logic         ev [2];
    logic [63:0]  ed [2];
    int           errors = 0;
    int           checks = 0;
    int           cycles = 0;
    bit           done = 0;

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [63:0] exp_readout(int p);
        return {32'(mw) | 32'(DEPTH), mfrz[p], 31'(mrp[p])};
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int p = 0; p < 2; p++) begin
            check64({tag, " readout"}, ptr_rdata[p], exp_readout(p));
            check64({tag, " valid"}, 64'(dat_valid[p]), 64'(ev[p]));
            if (ev[p]) check64({tag, " data"}, dat_rdata[p], ed[p]);
            check64("R10 zero-depth outputs",
                    z_rdata[p] | z_data[p] | 64'(z_valid[p]), 64'd0);
        end
    endtask

    task automatic tick(string tag);
        logic fr;
        @(posedge clk);
        if (!rst) begin
            fr = mfrz[0] | mfrz[1];
            for (int p = 0; p < 2; p++) begin
                ev[p] = 1'b0;
                if (ptr_we[p]) begin
                    mfrz[p] = ptr_wdata[p][31];
                    mrp[p]  = int'(ptr_wdata[p][30:0]) % RD;
                end else if (dat_re[p]) begin
                    ed[p]  = mmem[mrp[p] / 4][(mrp[p] % 4) * 64 +: 64];
                    ev[p]  = 1'b1;
                    mrp[p] = (mrp[p] + 1) % RD;
                end
            end
            if (!fr) begin
                mmem[mw] = rec_in;
                mw = (mw + 1) % DEPTH;
            end
        end
        @(negedge clk);
        check_all(tag);
        ptr_we = '0;
        dat_re = '0;
        rec_in = rnd256();
    endtask

    task automatic set_ptr(int p, logic [63:0] v);
        ptr_we[p]    = 1'b1;
        ptr_wdata[p] = v;
    endtask

    initial begin
        void'($urandom(32'd1234));
        mw = 0;
        for (int p = 0; p < 2; p++) begin
            mrp[p] = 0; mfrz[p] = 0; ev[p] = 0; ed[p] = '0;
        end
        @(negedge clk);
        @(negedge clk);
        check_all("R1 during reset");
        rst = 1'b0;
        rec_in = rnd256();
        tick("R1 after release");

        // R2: free-running capture through a wrap of the write position
        for (int i = 0; i < DEPTH + 60; i++) tick("R2 free run");

        // R4: freeze via port 1 with junk in the ignored bits
        set_ptr(1, {32'hDEAD_BEEF, 1'b1, 18'h3_FFFF, 13'd5});
        tick("R4 pointer load upper ignored");
        for (int i = 0; i < 4; i++) tick("R5 frozen hold");

        // R7: port 0 read position wraps at DEPTH*4
        set_ptr(0, 64'(RD - 2));
        tick("R3 readout fields");
        for (int i = 0; i < 4; i++) begin
            dat_re[0] = 1'b1;
            tick("R7 read wrap / R6 data");
        end

        // R8: both ports reading together
        for (int i = 0; i < 6; i++) begin
            dat_re = 2'b11;
            tick("R8 dual read");
        end

        // R9: pointer write and data read on the same cycle
        dat_re[0] = 1'b1;
        set_ptr(0, 64'd40);
        tick("R9 write wins");
        tick("R9 no data after collision");

        // release freeze, capture resumes
        set_ptr(1, 64'd0);
        tick("R5 unfreeze");
        for (int i = 0; i < 5; i++) tick("R2 resume");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < 2; p++) begin
                if ($urandom_range(99) < 4)
                    set_ptr(p, {$urandom, ($urandom_range(1) == 1), 31'($urandom)});
                if ($urandom_range(99) < 40) dat_re[p] = 1'b1;
            end
            tick("R6 random mix");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule